// File: doc/BRIEF.md
# Opcode-Decoded 8-bit Accumulator ALU

This block executes the accumulator arithmetic and logic instructions of an 8-bit processor. It takes the opcode byte, the current accumulator, the current flag byte and one operand byte, then returns the new accumulator, the new flag byte and a write strobe for the accumulator. The operand is already fetched: a register, a memory byte addressed through the pointer pair, or an immediate byte that follows the opcode.

The operation comes straight from opcode bits 5:3 and the source slot from opcode bits 2:0. The source decode is driven out combinationally, so the surrounding datapath can fetch the operand in the same cycle. The arithmetic results and flags are registered and appear one clock after `op_valid`. A compare sets the flags of a subtraction and leaves the accumulator alone. An opcode outside the two accepted groups is flagged as invalid and changes nothing.

Top module: `alu8_core`

## Requirements
- R1: Legal opcodes are 0x80–0xBF (register group) and the eight immediate forms 0xC6, 0xCE, 0xD6, 0xDE, 0xE6, 0xEE, 0xF6, 0xFE. In both groups, opcode bits 5:3 give the operation in this order: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 xor, 6 or, 7 compare. `src_reg` equals opcode bits 2:0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A). `src_imm` is 1 exactly for the eight immediate opcodes.
- R2: Add and add-with-carry write A+operand(+C for the carry form) mod 256. In the flag byte: bit 0 (C) is the carry out of bit 7, bit 4 (H) is the carry out of bit 3, bit 2 (P/V) is signed overflow, and bit 1 (N) is 0.
- R3: Subtract and subtract-with-borrow write A−operand(−C for the borrow form) mod 256. C is the borrow out of bit 7, H is the borrow out of bit 3, P/V is signed overflow, and N is 1.
- R4: Compare sets the flags exactly as subtract does. `acc_we` is 0 and `acc_out` equals the incoming accumulator.
- R5: And sets H to 1, clears C and N, and sets P/V to 1 when the result has an even number of one bits.
- R6: Or and xor clear H, C and N, and set P/V to even parity of the result.
- R7: Flag bit 7 (S) equals bit 7 of the operation result, and bit 6 (Z) is 1 when that result is zero. For compare, the result is the difference.
- R8: An illegal opcode gives `bad_op`=1 and `acc_we`=0, with `acc_out` equal to `acc_in` and `flags_out` equal to `flags_in`.
- R9: The outputs register one cycle after `op_valid`, and `done` pulses for that cycle. In a cycle after `op_valid`=0, `done`, `acc_we` and `bad_op` are 0 and `acc_out`/`flags_out` hold their values.
- R10: Synchronous active-high `rst` clears `acc_out`, `flags_out`, `acc_we`, `bad_op` and `done` to 0.
- R11: Flag bits 5 and 3 are copied from `flags_in` for every legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode and operands are present this cycle |
| opcode | input | 8 | Instruction byte |
| acc_in | input | DATA_W | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| operand | input | DATA_W | Fetched source byte |
| src_reg | output | 3 | Source slot from opcode bits 2:0 (combinational) |
| src_imm | output | 1 | Opcode is an immediate form (combinational) |
| acc_out | output | DATA_W | New accumulator value |
| flags_out | output | 8 | New flag byte |
| acc_we | output | 1 | Accumulator write enable |
| bad_op | output | 1 | Invalid instruction |
| done | output | 1 | Result valid this cycle |

## Verification
The bench builds the block with the default DATA_W of 8, so the nibble carry sits at bit 4 and the sign at bit 7. This makes every flag rule reachable with byte-sized hand-worked vectors. The vectors cover carries and borrows at both the nibble and the byte boundary, signed overflow in both directions, zero results, and parity of odd and even weight. A sweep over all 256 opcodes checks legality and the source decode. Directed steps then cover reset, the hold behaviour between operations, and the pass-through of the two spare flag bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  // Operation encoding follows opcode bits 5:3.
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // Flag byte layout; neighbours decode these positions.
  localparam int FLAG_W = 8;
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_Y   = 5;
  localparam int FB_H   = 4;
  localparam int FB_X   = 3;
  localparam int FB_PV  = 2;
  localparam int FB_N   = 1;
  localparam int FB_C   = 0;

  typedef struct packed {
    alu_op_e    op;
    logic       legal;
    logic       imm;
    logic [2:0] src;
  } dec_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  logic reg_grp;
  logic imm_grp;

  always_comb begin
    reg_grp   = (opcode[7:6] == 2'b10);
    imm_grp   = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b110);
    dec.op    = alu_op_e'(opcode[5:3]);
    dec.legal = reg_grp || imm_grp;
    dec.imm   = imm_grp;
    dec.src   = opcode[2:0];
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ci,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              h_out,
  output logic              v_out
);

  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W:0] ax, bx, cx, full;
  logic [HALF:0]   al, bl, cl, low;

  always_comb begin
    ax = {1'b0, a};
    bx = {1'b0, b};
    cx = {{DATA_W{1'b0}}, ci};
    al = {1'b0, a[HALF-1:0]};
    bl = {1'b0, b[HALF-1:0]};
    cl = {{HALF{1'b0}}, ci};
    if (sub) begin
      full = ax - bx - cx;
      low  = al - bl - cl;
    end else begin
      full = ax + bx + cx;
      low  = al + bl + cl;
    end
    res   = full[MSB:0];
    c_out = full[DATA_W];
    h_out = low[HALF];
    if (sub) v_out = (a[MSB] ^ b[MSB]) & (full[MSB] ^ a[MSB]);
    else     v_out = ~(a[MSB] ^ b[MSB]) & (full[MSB] ^ a[MSB]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,   // 0 and, 1 xor, 2 or
  output logic [DATA_W-1:0] res,
  output logic              even
);

  logic [DATA_W:0] par_chain;

  always_comb begin
    case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a ^ b;
      default: res = a | b;
    endcase
  end

  // Parity as an explicit chain so its depth follows DATA_W.
  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res[i];
  end
  assign even = par_chain[DATA_W];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [7:0]        flags_in,
  input  logic [DATA_W-1:0] operand,
  output logic [2:0]        src_reg,
  output logic              src_imm,
  output logic [DATA_W-1:0] acc_out,
  output logic [7:0]        flags_out,
  output logic              acc_we,
  output logic              bad_op,
  output logic              done
);

  localparam int MSB = DATA_W - 1;

  dec_t dec;

  alu8_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  assign src_reg = dec.src;
  assign src_imm = dec.imm;

  logic              is_sub, use_c;
  logic [DATA_W-1:0] ar_res, lg_res, res;
  logic              ar_c, ar_h, ar_v, lg_even;

  always_comb begin
    is_sub = (dec.op == OP_SUB) || (dec.op == OP_SBC) || (dec.op == OP_CMP);
    use_c  = (dec.op == OP_ADC) || (dec.op == OP_SBC);
  end

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .a     (acc_in),
    .b     (operand),
    .ci    (use_c & flags_in[FB_C]),
    .sub   (is_sub),
    .res   (ar_res),
    .c_out (ar_c),
    .h_out (ar_h),
    .v_out (ar_v)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a    (acc_in),
    .b    (operand),
    .sel  (dec.op[1:0]),
    .res  (lg_res),
    .even (lg_even)
  );

  logic             logic_op;
  logic [FLAG_W-1:0] nf;

  always_comb begin
    logic_op = dec.op[2] && (dec.op != OP_CMP);
    res      = logic_op ? lg_res : ar_res;
    nf         = '0;
    nf[FB_Y]   = flags_in[FB_Y];
    nf[FB_X]   = flags_in[FB_X];
    nf[FB_S]   = res[MSB];
    nf[FB_Z]   = (res == '0);
    if (logic_op) begin
      nf[FB_H]  = (dec.op == OP_AND);
      nf[FB_PV] = lg_even;
      nf[FB_N]  = 1'b0;
      nf[FB_C]  = 1'b0;
    end else begin
      nf[FB_H]  = ar_h;
      nf[FB_PV] = ar_v;
      nf[FB_N]  = is_sub;
      nf[FB_C]  = ar_c;
    end
  end

  logic writes;
  assign writes = dec.legal && (dec.op != OP_CMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out   <= '0;
      flags_out <= '0;
      acc_we    <= 1'b0;
      bad_op    <= 1'b0;
      done      <= 1'b0;
    end else if (op_valid) begin
      done      <= 1'b1;
      bad_op    <= !dec.legal;
      acc_we    <= writes;
      acc_out   <= writes ? res : acc_in;
      flags_out <= dec.legal ? nf : flags_in;
    end else begin
      done      <= 1'b0;
      bad_op    <= 1'b0;
      acc_we    <= 1'b0;
    end
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] acc_out,
  input logic [7:0]        flags_out,
  input logic              acc_we,
  input logic              bad_op,
  input logic              done
);

  logic legal_in, cmp_in, logic_in;
  always_comb begin
    legal_in = (opcode[7:6] == 2'b10) ||
               ((opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b110));
    cmp_in   = legal_in && (opcode[5:3] == 3'd7);
    logic_in = legal_in && opcode[5] && !(opcode[4] && opcode[3]);
  end

  p_done_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!done && !acc_we && !bad_op));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !$past(rst)) |=> ($stable(acc_out) && $stable(flags_out)));
  p_bad_no_we_r8: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> !acc_we);
  p_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !legal_in) |=> bad_op);
  p_cmp_no_we_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_in) |=> (!acc_we && !bad_op));
  p_sz_r7: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> ((flags_out[6] == (acc_out == '0)) && (flags_out[7] == acc_out[DATA_W-1])));
  p_parity_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && logic_in) |=> ((flags_out[2] == ~^acc_out) && !flags_out[0] && !flags_out[1]));

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .acc_out   (acc_out),
  .flags_out (flags_out),
  .acc_we    (acc_we),
  .bad_op    (bad_op),
  .done      (done)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  localparam int DATA_W = 8;
  localparam int NV     = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [7:0]        opcode = 8'h00;
  logic [DATA_W-1:0] acc_in = '0;
  logic [7:0]        flags_in = 8'h00;
  logic [DATA_W-1:0] operand = '0;
  logic [2:0]        src_reg;
  logic              src_imm;
  logic [DATA_W-1:0] acc_out;
  logic [7:0]        flags_out;
  logic              acc_we, bad_op, done;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_core #(.DATA_W(DATA_W)) dut (
    .clk, .rst, .op_valid, .opcode, .acc_in, .flags_in, .operand,
    .src_reg, .src_imm, .acc_out, .flags_out, .acc_we, .bad_op, .done
  );

  // {opcode, acc, flags, operand, exp_acc, exp_flags, exp_we, exp_bad}
  localparam logic [49:0] VECS [0:NV-1] = '{
    {8'h80, 8'h3A, 8'h00, 8'hC6, 8'h00, 8'h51, 1'b1, 1'b0}, // R2 byte+nibble carry, zero
    {8'hCE, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94, 1'b1, 1'b0}, // R2 carry-in, overflow
    {8'h91, 8'h10, 8'h00, 8'h01, 8'h0F, 8'h12, 1'b1, 1'b0}, // R3 nibble borrow
    {8'h9E, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h93, 1'b1, 1'b0}, // R3 borrow-in wrap
    {8'hD6, 8'h80, 8'h00, 8'h01, 8'h7F, 8'h16, 1'b1, 1'b0}, // R3 overflow
    {8'hFE, 8'h42, 8'h00, 8'h42, 8'h42, 8'h42, 1'b0, 1'b0}, // R4 equal compare
    {8'hB8, 8'h05, 8'h00, 8'h06, 8'h05, 8'h93, 1'b0, 1'b0}, // R4 compare below
    {8'hE6, 8'hF0, 8'hFF, 8'h3C, 8'h30, 8'h3C, 1'b1, 1'b0}, // R5 and, R11 spare bits
    {8'hAF, 8'h5A, 8'h13, 8'h5A, 8'h00, 8'h44, 1'b1, 1'b0}, // R6 xor to zero
    {8'hB2, 8'h80, 8'h00, 8'h01, 8'h81, 8'h84, 1'b1, 1'b0}, // R6 or, sign
    {8'h87, 8'h80, 8'h00, 8'h80, 8'h00, 8'h45, 1'b1, 1'b0}, // R2 negative overflow
    {8'hC3, 8'h12, 8'hA5, 8'h34, 8'h12, 8'hA5, 1'b0, 1'b1}, // R8 illegal
    {8'h3C, 8'h77, 8'h5A, 8'h01, 8'h77, 8'h5A, 1'b0, 1'b1}, // R8 illegal low page
    {8'h88, 8'h0F, 8'h29, 8'h00, 8'h10, 8'h38, 1'b1, 1'b0}, // R11 pass-through, R2
    {8'h9F, 8'h20, 8'h01, 8'h20, 8'hFF, 8'h93, 1'b1, 1'b0}  // R3 self minus borrow
  };

  localparam int VREQ [0:NV-1] = '{2, 2, 3, 3, 3, 4, 4, 5, 6, 6, 2, 8, 8, 11, 3};

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive at negedge; result registers at next posedge; sample at following negedge.
  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f, input logic [7:0] b);
    @(negedge clk);
    opcode = op; acc_in = a; flags_in = f; operand = b; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state, with activity on the inputs during reset
    op_valid = 1'b1; opcode = 8'h80; acc_in = 8'h11; operand = 8'h22;
    repeat (3) @(negedge clk);
    check(10, "reset acc_out", acc_out, 0);
    check(10, "reset flags_out", flags_out, 0);
    check(10, "reset strobes", {acc_we, bad_op, done}, 0);
    op_valid = 1'b0; rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i][49:42], VECS[i][41:34], VECS[i][33:26], VECS[i][25:18]);
      check(VREQ[i], $sformatf("vec %0d acc_out", i), acc_out, VECS[i][17:10]);
      check(VREQ[i], $sformatf("vec %0d flags_out", i), flags_out, VECS[i][9:2]);
      check(VREQ[i], $sformatf("vec %0d acc_we", i), acc_we, VECS[i][1]);
      check(VREQ[i], $sformatf("vec %0d bad_op", i), bad_op, VECS[i][0]);
      check(9, $sformatf("vec %0d done", i), done, 1);
    end

    // R9 hold: one idle cycle, outputs keep the last result (0x9F vector)
    @(negedge clk);
    check(9, "idle strobes", {acc_we, bad_op, done}, 0);
    check(9, "idle acc hold", acc_out, 8'hFF);
    check(9, "idle flags hold", flags_out, 8'h93);

    // R9 back-to-back: two ops on consecutive cycles
    @(negedge clk);
    opcode = 8'hC6; acc_in = 8'h01; flags_in = 8'h00; operand = 8'h01; op_valid = 1'b1;
    @(negedge clk);
    check(9, "b2b first acc", acc_out, 8'h02);
    opcode = 8'hF6; acc_in = 8'h0F; operand = 8'hF0;
    @(negedge clk);
    op_valid = 1'b0;
    check(9, "b2b second acc", acc_out, 8'hFF);
    check(6, "or all ones flags", flags_out, 8'h84);
    check(9, "b2b done", done, 1);

    // R1 decode sweep over every opcode
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      logic       leg, imm;
      o   = 8'(op);
      imm = (o[7:6] == 2'b11) && (o[2:0] == 3'b110);
      leg = (o[7:6] == 2'b10) || imm;
      run_op(o, 8'h00, 8'h00, 8'h00);
      check(1, $sformatf("legality of %02h", o), bad_op, !leg);
      opcode = o;
      #1;
      check(1, $sformatf("src_imm of %02h", o), src_imm, imm);
      if (leg && !imm) check(1, $sformatf("src_reg of %02h", o), src_reg, o[2:0]);
    end

    // R10 reset mid-stream clears a pending result
    run_op(8'h80, 8'h01, 8'h00, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(10, "late reset acc_out", acc_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule